// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Replay-on-Miss

This block places a small data cache between a CPU-side request port and a byte-addressable backing memory. The backing memory is part of the block. The CPU presents a 32-bit byte address, a read/write strobe and a 32-bit write word.

When the addressed line is resident, the access finishes in the same cycle. The `hit` output is raised, and on a read `rdata` carries the word. On a write, the word is stored in the cached line and the line is marked dirty. When the line is not resident, the cache raises `miss`. If the line currently in that slot is dirty, the cache first copies it back to memory. It then loads the requested line and finally pulses `done` for one cycle.

The cache never returns data at the end of a miss. Instead, the CPU replays the identical request on the cycle after `done`. That replayed request is then served as a hit.

Top module: `wbc_top`

## Requirements
- R1: Address decoding works as follows: bits [3:2] pick the word in a line, bits [5:4] pick one of 4 line slots, and bits [9:6] are the stored tag. Bits [1:0] and bits 31..10 are ignored, so addresses that differ only in those bits reach the same word.
- R2: After synchronous reset, every slot is invalid and `hit`, `miss` and `done` are low. Each memory byte at address a holds (7*a+3) mod 256. A word is formed little-endian, with its lowest-addressed byte in bits [7:0].
- R3: A request to a resident line raises `hit` in the same cycle, and on a read `rdata` holds the word in that cycle.
- R4: `hit` and `miss` are never high together. With no request pending and no miss in progress, both are low.
- R5: A miss keeps `miss` high from the request cycle through the cycle in which `done` is high. `done` is high for exactly one cycle. `miss` is low in the following cycle unless a new miss starts.
- R6: When the same request is replayed in the cycle after `done`, it hits, and a read returns the memory contents of that word.
- R7: A miss whose slot holds a valid dirty line writes the whole 16-byte victim back to its old address before the fill. `done` then comes 2*MEM_LAT+1 cycles after the request cycle.
- R8: A miss whose slot is invalid or clean skips the write-back. `done` then comes MEM_LAT+1 cycles after the request cycle.
- R9: Request inputs presented while a miss is in progress have no effect on the cache or on memory.
- R10: A write hit replaces only the addressed word of the line. The other words of the line keep their values, including after the line is written back and reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A CPU request is present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Word to write |
| hit | output | 1 | Request served this cycle |
| miss | output | 1 | Request missed, or a miss is in progress |
| rdata | output | 32 | Read word, valid when `hit` is high |
| done | output | 1 | One-cycle pulse when the line has been loaded |

## Verification
The hardest situation to reach is a dirty eviction whose victim line was only partly written. In that case the write-back must carry both the new words and the untouched original words to memory. The sweep reads every memory word once, which leaves all slots clean. It then writes three of the four words in every line, so each later miss evicts a dirty, partly modified victim. A final pass reads all words back through addresses with random upper and low bits. That pass shows that the written words and the untouched fourth words both survived the trip through memory. During every miss wait, the bench drives conflicting addresses and strobes, so any leak of those inputs into the cache would corrupt the later reads.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } wbc_state_e;

  // Power-up content of backing memory byte a.
  function automatic logic [7:0] seed_byte(input int unsigned a);
    logic [31:0] v;
    v = a * 7 + 3;
    return v[7:0];
  endfunction

endpackage

// File: rtl/wbc_lines.sv
module wbc_lines #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 4,
  parameter int WORD_W    = 32,
  parameter int LINE_WDS  = 4,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int WSEL_W   = $clog2(LINE_WDS),
  localparam int LINE_W   = WORD_W * LINE_WDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [WSEL_W-1:0] lk_wsel,
  output logic              lk_hit,
  output logic [WORD_W-1:0] lk_word,
  output logic              lk_dirty,
  output logic [TAG_W-1:0]  lk_vtag,
  output logic [LINE_W-1:0] lk_line,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line
);

  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [LINE_W-1:0]    data_q [NUM_LINES];

  assign lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_dirty = valid_q[lk_idx] && dirty_q[lk_idx];
  assign lk_vtag  = tag_q[lk_idx];
  assign lk_line  = data_q[lk_idx];
  assign lk_word  = data_q[lk_idx][lk_wsel*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[lk_idx] <= 1'b1;
      dirty_q[lk_idx] <= 1'b0;
    end else if (wr_en) begin
      dirty_q[lk_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[lk_idx]  <= lk_tag;
      data_q[lk_idx] <= fill_line;
    end else if (wr_en) begin
      data_q[lk_idx][lk_wsel*WORD_W +: WORD_W] <= wr_word;
    end
  end

  // R10
  wr_needs_resident_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> lk_hit);

  // R7
  fill_not_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(fill_en && wr_en));

endmodule

// File: rtl/wbc_mem.sv
module wbc_mem
  import wbc_pkg::*;
#(
  parameter int MEM_BYTES  = 1024,
  parameter int LINE_BYTES = 16,
  parameter int MEM_LAT    = 4,
  localparam int MLINES    = MEM_BYTES / LINE_BYTES,
  localparam int MLINE_W   = $clog2(MLINES),
  localparam int LINE_W    = 8 * LINE_BYTES,
  localparam int CNT_W     = $clog2(MEM_LAT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xfer_req,
  input  logic               xfer_we,
  input  logic [MLINE_W-1:0] xfer_line,
  input  logic [LINE_W-1:0]  xfer_wline,
  output logic [LINE_W-1:0]  xfer_rline,
  output logic               xfer_ack
);

  logic [LINE_W-1:0] mem_q [MLINES];
  logic [CNT_W-1:0]  cnt_q;

  assign xfer_ack   = xfer_req && (cnt_q == CNT_W'(MEM_LAT - 1));
  assign xfer_rline = mem_q[xfer_line];

  always_ff @(posedge clk) begin
    if (rst || !xfer_req || xfer_ack) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < MLINES; l++)
        for (int b = 0; b < LINE_BYTES; b++)
          mem_q[l][b*8 +: 8] <= seed_byte(l * LINE_BYTES + b);
    end else if (xfer_ack && xfer_we) begin
      mem_q[xfer_line] <= xfer_wline;
    end
  end

  // R8
  lat_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(MEM_LAT));

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int MEM_LAT = 4,
  parameter int IDX_W   = 2,
  parameter int TAG_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             lk_hit,
  input  logic             lk_dirty,
  input  logic             xfer_ack,
  output logic             busy,
  output logic             hit,
  output logic             miss,
  output logic             done,
  output logic             wr_en,
  output logic             fill_en,
  output logic             xfer_req,
  output logic             xfer_we,
  output logic [IDX_W-1:0] miss_idx,
  output logic [TAG_W-1:0] miss_tag
);

  wbc_state_e state_q, state_d;
  logic       idle, new_miss;

  assign idle     = (state_q == ST_IDLE);
  assign busy     = !idle;
  assign new_miss = idle && req_valid && !lk_hit;
  assign hit      = idle && req_valid && lk_hit;
  assign miss     = new_miss || busy;
  assign done     = (state_q == ST_DONE);
  assign wr_en    = hit && req_we;
  assign xfer_req = (state_q == ST_EVICT) || (state_q == ST_FILL);
  assign xfer_we  = (state_q == ST_EVICT);
  assign fill_en  = (state_q == ST_FILL) && xfer_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (new_miss) state_d = lk_dirty ? ST_EVICT : ST_FILL;
      ST_EVICT: if (xfer_ack) state_d = ST_FILL;
      ST_FILL:  if (xfer_ack) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_idx <= '0;
      miss_tag <= '0;
    end else if (new_miss) begin
      miss_idx <= req_idx;
      miss_tag <= req_tag;
    end
  end

  // Checker state: cycles spent transferring during the current miss.
  localparam int BC_W = $clog2(2 * MEM_LAT + 2);
  logic [BC_W-1:0] xfer_cyc_q;
  always_ff @(posedge clk) begin
    if (rst || idle) xfer_cyc_q <= '0;
    else if (xfer_req) xfer_cyc_q <= xfer_cyc_q + 1'b1;
  end

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (miss && !done) |=> miss);

  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (xfer_cyc_q == BC_W'(MEM_LAT) || xfer_cyc_q == BC_W'(2 * MEM_LAT)));

endmodule

// File: rtl/wbc_top.sv
module wbc_top
  import wbc_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter int CACHE_BYTES = 64,
  parameter int WORD_BYTES  = 4,
  parameter int LINE_WDS    = 4,
  parameter int MEM_LAT     = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_we,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        hit,
  output logic        miss,
  output logic [31:0] rdata,
  output logic        done
);

  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int LINE_BYTES = WORD_BYTES * LINE_WDS;
  localparam int LINE_W     = 8 * LINE_BYTES;
  localparam int NUM_LINES  = CACHE_BYTES / LINE_BYTES;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int WSEL_W     = $clog2(LINE_WDS);
  localparam int IDX_W      = $clog2(NUM_LINES);
  localparam int MADDR_W    = $clog2(MEM_BYTES);
  localparam int TAG_W      = MADDR_W - OFF_W - WSEL_W - IDX_W;
  localparam int MLINE_W    = TAG_W + IDX_W;

  logic [WSEL_W-1:0] a_wsel;
  logic [IDX_W-1:0]  a_idx, arr_idx, miss_idx;
  logic [TAG_W-1:0]  a_tag, arr_tag, miss_tag, vtag;
  logic              lk_hit, lk_dirty, busy, wr_en, fill_en;
  logic              xfer_req, xfer_we, xfer_ack;
  logic [LINE_W-1:0] lk_line, rline;
  logic [MLINE_W-1:0] xfer_line;
  logic              unused_addr;

  assign a_wsel = req_addr[OFF_W +: WSEL_W];
  assign a_idx  = req_addr[OFF_W + WSEL_W +: IDX_W];
  assign a_tag  = req_addr[OFF_W + WSEL_W + IDX_W +: TAG_W];
  assign unused_addr = ^{req_addr[31:MADDR_W], req_addr[OFF_W-1:0]};

  assign arr_idx   = busy ? miss_idx : a_idx;
  assign arr_tag   = busy ? miss_tag : a_tag;
  assign xfer_line = xfer_we ? {vtag, miss_idx} : {miss_tag, miss_idx};

  wbc_lines #(
    .NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .WORD_W(WORD_W), .LINE_WDS(LINE_WDS)
  ) i_lines (
    .clk(clk), .rst(rst),
    .lk_idx(arr_idx), .lk_tag(arr_tag), .lk_wsel(a_wsel),
    .lk_hit(lk_hit), .lk_word(rdata), .lk_dirty(lk_dirty),
    .lk_vtag(vtag), .lk_line(lk_line),
    .wr_en(wr_en), .wr_word(req_wdata),
    .fill_en(fill_en), .fill_line(rline)
  );

  wbc_mem #(
    .MEM_BYTES(MEM_BYTES), .LINE_BYTES(LINE_BYTES), .MEM_LAT(MEM_LAT)
  ) i_mem (
    .clk(clk), .rst(rst),
    .xfer_req(xfer_req), .xfer_we(xfer_we), .xfer_line(xfer_line),
    .xfer_wline(lk_line), .xfer_rline(rline), .xfer_ack(xfer_ack)
  );

  wbc_ctrl #(
    .MEM_LAT(MEM_LAT), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) i_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_we(req_we),
    .req_idx(a_idx), .req_tag(a_tag),
    .lk_hit(lk_hit), .lk_dirty(lk_dirty), .xfer_ack(xfer_ack),
    .busy(busy), .hit(hit), .miss(miss), .done(done),
    .wr_en(wr_en), .fill_en(fill_en),
    .xfer_req(xfer_req), .xfer_we(xfer_we),
    .miss_idx(miss_idx), .miss_tag(miss_tag)
  );

  logic done_q;
  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= done;
  end

  // R4
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hit && miss));

  // R6
  replay_hits_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && req_valid && a_idx == miss_idx && a_tag == miss_tag) |-> hit);

endmodule

// File: tb/test_wbc_top.sv
module test_wbc_top;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_we;
  logic [31:0] req_addr, req_wdata;
  logic        hit, miss, done;
  logic [31:0] rdata;

  int errors = 0;
  int checks = 0;

  logic [31:0] model [256];
  bit          mv [4];
  bit          md [4];
  int          mt [4];

  always #5 clk = ~clk;

  wbc_top #(.MEM_LAT(LAT)) i_wbc_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .hit(hit), .miss(miss), .rdata(rdata), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] seed_word(input int w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = 8'((4 * w + k) * 7 + 3);
    return r;
  endfunction

  function automatic logic [31:0] wval(input int w);
    return (32'(w) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic access(input int w, input bit we, input logic [31:0] wd,
                        input logic [31:0] junk);
    int idx, tag, n, exp_lat;
    bit exp_hit, seen;
    logic [31:0] addr;
    idx = (w >> 2) & 3;
    tag = w >> 4;
    addr = (junk << 10) | (32'(w) << 2) | (junk & 32'h3);
    exp_hit = mv[idx] && mt[idx] == tag;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    #1;
    if (exp_hit) begin
      // R3 / R1
      check(hit === 1'b1 && miss === 1'b0, "R3 hit", {30'd0, hit, miss}, 32'h2);
      if (!we) check(rdata === model[w], "R3 rdata", rdata, model[w]);
    end else begin
      // R4 / R5
      check(miss === 1'b1 && hit === 1'b0, "R5 miss", {30'd0, hit, miss}, 32'h1);
      exp_lat = (mv[idx] && md[idx]) ? 2 * LAT + 1 : LAT + 1;
      n = 0; seen = 0;
      while (!seen && n < 40) begin
        @(posedge clk); #1;
        // R9: conflicting inputs during the miss
        req_addr = addr ^ 32'h0000_01F4; req_we = !we; req_wdata = ~wd;
        @(negedge clk); #1;
        n++;
        if (done === 1'b1) seen = 1;
        else check(miss === 1'b1, "R5 miss held", {31'd0, miss}, 32'h1);
      end
      // R7 / R8
      check(n == exp_lat, (exp_lat > LAT + 1) ? "R7 dirty latency" : "R8 clean latency",
            n, exp_lat);
      @(posedge clk); #1;
      req_addr = addr; req_we = we; req_wdata = wd;
      @(negedge clk); #1;
      // R6 / R5
      check(hit === 1'b1 && miss === 1'b0 && done === 1'b0, "R6 replay hit",
            {29'd0, hit, miss, done}, 32'h4);
      if (!we) check(rdata === model[w], "R6 replay rdata", rdata, model[w]);
      mv[idx] = 1; md[idx] = 0; mt[idx] = tag;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (we) begin
      md[idx] = 1;
      model[w] = wd;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < 256; i++) model[i] = seed_word(i);
    for (int i = 0; i < 4; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    // R2 / R4: quiet after reset
    check(hit === 1'b0 && miss === 1'b0 && done === 1'b0, "R2 reset outputs",
          {29'd0, hit, miss, done}, 32'h0);
    // R2: cold reads of every word return seed contents
    for (int w = 0; w < 256; w++) access(w, 1'b0, 32'h0, 32'h0);
    // R10: write three of four words per line; dirty evictions follow
    for (int w = 0; w < 256; w++)
      if ((w & 3) != 3) access(w, 1'b1, wval(w), 32'h0);
    // R1: read back through aliased addresses
    for (int w = 0; w < 256; w++)
      access(w, 1'b0, 32'h0, 32'(w) * 32'h0001_3579 + 32'h5);
    // R10: final pass with wrapped order after overwrite hits
    for (int w = 0; w < 16; w++) access(w, 1'b1, ~wval(w), 32'h3);
    for (int w = 0; w < 64; w++) access(255 - w, 1'b0, 32'h0, 32'h0);
    for (int w = 0; w < 16; w++) access(w, 1'b0, 32'h0, 32'h1);
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule